// File: doc/BRIEF.md
# External Bus Cycle Wait-State Sequencer

This block runs one external bus access at a time through a fixed series of bus states and stretches the access with wait states. A start strobe launches a cycle: first an address state (T1), then the first data state (T2), then zero or more wait states (TW), then the closing data state (T3), after which the sequencer returns to idle (IDLE). Wait states always sit between T2 and T3, for reads and for writes alike.

How many wait states are inserted depends on a mode and on the address region being accessed. Each of three regions has its own 2-bit wait field: the normal area, a 256-kbyte extended area, and a second extended area. In the programmed mode, the field alone sets the count. In the pin-only mode, an active-low WAIT input alone stretches the cycle. In the combined mode, the field's count is inserted first and WAIT is then honoured. WAIT is synchronized and then sampled on a falling clock edge. The region, mode, field values and direction are captured when the cycle starts.

The outputs are the current bus state, a read strobe, a write strobe and a one-clock done pulse.

Top module: `bus_wait_seq`

## Requirements
- R1: `bus_state` encodes IDLE=0, T1=1, T2=2, TW=3 and T3=4. An accepted cycle moves through IDLE, T1, T2, zero or more TW, T3 and back to IDLE, one state per clock.
- R2: `start` is acted on only in IDLE. A `start` pulse while a cycle is running does not alter that cycle, and it does not begin a new one after that cycle ends.
- R3: With `mode`=0 (programmed), and also with the unused code `mode`=3, exactly the selected field's value (0 to 3) of TW states is inserted, whatever the level of `wait_n`.
- R4: `region`=0 selects `wc_def`, `region`=1 selects `wc_ext`, `region`=2 selects `wc_cp`, and `region`=3 falls back to `wc_def`.
- R5: With `mode`=1 (pin only), no TW state is inserted unconditionally. A TW state is added at each wait decision that finds WAIT asserted.
- R6: With `mode`=2 (combined), the field's count of TW states is inserted unconditionally first. After that, WAIT decisions apply as in R5.
- R7: `wait_n` passes through one rising-edge flop and then one falling-edge flop. A wait decision is made at the end of the last T2 or TW state. It uses the `wait_n` level present just before that state began. If `wait_n` is held low from before the start edge until just after the r-th rising edge following it, the cycle carries max(n, r) TW states in combined mode and r in pin-only mode, where n is the field value.
- R8: While WAIT is sampled low, TW states keep being inserted with no upper bound. The cycle resumes toward T3 only after WAIT is sampled high.
- R9: `rd_sel`=1 selects a read and `rd_sel`=0 a write. `rd_stb` (read) or `wr_stb` (write) is high in T2, TW and T3 of the cycle, and never both at once.
- R10: `done` is high for exactly one clock per cycle, in T3.
- R11: Changing `region`, `mode`, the wait fields or `rd_sel` after the start edge has no effect on the running cycle.
- R12: During and after reset, the sequencer is in IDLE with `rd_stb`, `wr_stb` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bus cycle (taken in IDLE only) |
| rd_sel | input | 1 | 1 = read cycle, 0 = write cycle |
| region | input | 2 | Region of the access: 0 normal, 1 256-kbyte extended, 2 second extended, 3 normal |
| wc_def | input | WC_W | Wait field for the normal area |
| wc_ext | input | WC_W | Wait field for the 256-kbyte extended area |
| wc_cp | input | WC_W | Wait field for the second extended area |
| mode | input | 2 | 0 programmed, 1 pin only, 2 combined, 3 as programmed |
| wait_n | input | 1 | Active-low external WAIT request |
| bus_state | output | 3 | Current bus state code |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The assertions assume that `wait_n` and the configuration inputs are always at a defined level, and that `wait_n` only ever stretches a cycle; nothing assumes it is ever released. The programmed-count and minimum-count checks also assume that the configuration seen on the start edge is the configuration to model, so the checker captures that configuration itself on the same edge. The bench drives every input just after a falling edge. It holds the configuration steady for several clocks before each start, so the synchronizer starts from a settled level. It scrambles the configuration only after the start edge, which is the case R11 covers.

// File: rtl/bws_pkg.sv
package bws_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4
    } bus_state_e;

    typedef enum logic [1:0] {
        MD_PROG = 2'd0,
        MD_PIN  = 2'd1,
        MD_BOTH = 2'd2,
        MD_RSVD = 2'd3
    } wait_mode_e;

    typedef enum logic [1:0] {
        RG_NORM = 2'd0,
        RG_EXT  = 2'd1,
        RG_CP   = 2'd2,
        RG_ALT  = 2'd3
    } region_e;

endpackage

// File: rtl/bws_wait_sync.sv
module bws_wait_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_n,
    output logic wait_low
);
    logic meta_q;
    logic fall_q;

    // first stage on the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) meta_q <= 1'b1;
        else        meta_q <= wait_n;
    end

    // second stage samples on the falling edge, mid-state
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b1;
        else        fall_q <= meta_q;
    end

    assign wait_low = ~fall_q;
endmodule

// File: rtl/bws_cfg_latch.sv
module bws_cfg_latch #(
    parameter int WC_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            rd_sel,
    input  logic [1:0]      region,
    input  logic [WC_W-1:0] wc_def,
    input  logic [WC_W-1:0] wc_ext,
    input  logic [WC_W-1:0] wc_cp,
    input  logic [1:0]      mode,
    output logic [WC_W-1:0] cnt_q,
    output logic            pin_en_q,
    output logic            rd_q
);
    import bws_pkg::*;

    logic [WC_W-1:0] field_sel;
    logic [WC_W-1:0] cnt_d;
    logic            pin_en_d;

    always_comb begin
        unique case (region_e'(region))
            RG_EXT:  field_sel = wc_ext;
            RG_CP:   field_sel = wc_cp;
            default: field_sel = wc_def;
        endcase
    end

    always_comb begin
        unique case (wait_mode_e'(mode))
            MD_PIN: begin
                cnt_d    = '0;
                pin_en_d = 1'b1;
            end
            MD_BOTH: begin
                cnt_d    = field_sel;
                pin_en_d = 1'b1;
            end
            default: begin
                cnt_d    = field_sel;
                pin_en_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            pin_en_q <= 1'b0;
            rd_q     <= 1'b0;
        end else if (capture) begin
            cnt_q    <= cnt_d;
            pin_en_q <= pin_en_d;
            rd_q     <= rd_sel;
        end
    end
endmodule

// File: rtl/bws_wcount.sv
module bws_wcount #(
    parameter int WC_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WC_W-1:0] load_val,
    input  logic            dec,
    output logic            zero
);
    logic [WC_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                left_q <= '0;
        else if (load)             left_q <= load_val;
        else if (dec && !zero)     left_q <= left_q - 1'b1;
    end

    assign zero = (left_q == '0);
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq #(
    parameter int WC_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            rd_sel,
    input  logic [1:0]      region,
    input  logic [WC_W-1:0] wc_def,
    input  logic [WC_W-1:0] wc_ext,
    input  logic [WC_W-1:0] wc_cp,
    input  logic [1:0]      mode,
    input  logic            wait_n,
    output logic [2:0]      bus_state,
    output logic            rd_stb,
    output logic            wr_stb,
    output logic            done
);
    import bws_pkg::*;

    bus_state_e      state_q;
    bus_state_e      state_d;
    logic            wait_low;
    logic [WC_W-1:0] cnt_q;
    logic            pin_en_q;
    logic            rd_q;
    logic            cnt_zero;
    logic            capture;
    logic            in_data;

    assign capture = (state_q == ST_IDLE) && start;
    assign in_data = (state_q == ST_T2) || (state_q == ST_TW);

    bws_wait_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_n   (wait_n),
        .wait_low (wait_low)
    );

    bws_cfg_latch #(.WC_W(WC_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .rd_sel   (rd_sel),
        .region   (region),
        .wc_def   (wc_def),
        .wc_ext   (wc_ext),
        .wc_cp    (wc_cp),
        .mode     (mode),
        .cnt_q    (cnt_q),
        .pin_en_q (pin_en_q),
        .rd_q     (rd_q)
    );

    bws_wcount #(.WC_W(WC_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_T1),
        .load_val (cnt_q),
        .dec      (in_data),
        .zero     (cnt_zero)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_T1;
            ST_T1:   state_d = ST_T2;
            ST_T2,
            ST_TW: begin
                if (!cnt_zero)                state_d = ST_TW;
                else if (pin_en_q && wait_low) state_d = ST_TW;
                else                          state_d = ST_T3;
            end
            ST_T3:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state register
    always_comb begin
        rd_stb = 1'b0;
        wr_stb = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_T2, ST_TW: begin
                rd_stb = rd_q;
                wr_stb = ~rd_q;
            end
            ST_T3: begin
                rd_stb = rd_q;
                wr_stb = ~rd_q;
                done   = 1'b1;
            end
            default: ;
        endcase
    end

    assign bus_state = state_q;
endmodule

// File: rtl/bws_chk.sv
module bws_chk #(
    parameter int WC_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [1:0]      region,
    input logic [WC_W-1:0] wc_def,
    input logic [WC_W-1:0] wc_ext,
    input logic [WC_W-1:0] wc_cp,
    input logic [1:0]      mode,
    input logic [2:0]      bus_state,
    input logic            rd_stb,
    input logic            wr_stb,
    input logic            done
);
    import bws_pkg::*;

    logic [WC_W-1:0] n_q;
    logic            prog_q;
    logic            both_q;
    logic [15:0]     tw_seen;
    logic [WC_W-1:0] n_pick;

    always_comb begin
        if (region == 2'd1)      n_pick = wc_ext;
        else if (region == 2'd2) n_pick = wc_cp;
        else                     n_pick = wc_def;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q     <= '0;
            prog_q  <= 1'b0;
            both_q  <= 1'b0;
            tw_seen <= '0;
        end else if (bus_state == ST_IDLE && start) begin
            n_q     <= n_pick;
            prog_q  <= (mode == 2'd0) || (mode == 2'd3);
            both_q  <= (mode == 2'd2);
            tw_seen <= '0;
        end else if (bus_state == ST_TW && tw_seen != 16'hFFFF) begin
            tw_seen <= tw_seen + 16'd1;
        end
    end

    assert_start_to_t1_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_IDLE && start) |=> (bus_state == ST_T1));
    assert_t1_to_t2_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_T1) |=> (bus_state == ST_T2));
    assert_t3_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_T3) |=> (bus_state == ST_IDLE));
    assert_busy_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state != ST_IDLE) |=> (bus_state != ST_T1));
    assert_prog_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_T3 && prog_q) |-> (tw_seen == 16'(n_q)));
    assert_min_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_T3 && both_q) |-> (tw_seen >= 16'(n_q)));
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_IDLE) |-> (!rd_stb && !wr_stb && !done));
endmodule

bind bus_wait_seq bws_chk #(.WC_W(WC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .region    (region),
    .wc_def    (wc_def),
    .wc_ext    (wc_ext),
    .wc_cp     (wc_cp),
    .mode      (mode),
    .bus_state (bus_state),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .done      (done)
);

// File: tb/sim_bus_wait_seq.sv
module sim_bus_wait_seq;
    import bws_pkg::*;

    localparam int WC_W = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            rd_sel = 1'b0;
    logic [1:0]      region = '0;
    logic [WC_W-1:0] wc_def = '0;
    logic [WC_W-1:0] wc_ext = '0;
    logic [WC_W-1:0] wc_cp = '0;
    logic [1:0]      mode = '0;
    logic            wait_n = 1'b1;
    logic [2:0]      bus_state;
    logic            rd_stb;
    logic            wr_stb;
    logic            done;

    int nchk  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    bus_wait_seq #(.WC_W(WC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel),
        .region(region), .wc_def(wc_def), .wc_ext(wc_ext), .wc_cp(wc_cp),
        .mode(mode), .wait_n(wait_n), .bus_state(bus_state),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done)
    );

    typedef struct packed {
        logic [1:0] md;
        logic [1:0] rg;
        logic [1:0] fd;
        logic [1:0] fe;
        logic [1:0] fc;
        logic       rd;
        logic [9:0] rel;
        logic [9:0] exp_tw;
    } vec_t;

    // exp_tw: programmed modes -> field; pin only -> rel; combined -> max(field, rel)
    localparam vec_t VECS [12] = '{
        '{2'd0, 2'd0, 2'd2, 2'd1, 2'd3, 1'b1, 10'd10, 10'd2},
        '{2'd0, 2'd1, 2'd2, 2'd1, 2'd3, 1'b0, 10'd10, 10'd1},
        '{2'd0, 2'd2, 2'd2, 2'd1, 2'd3, 1'b1, 10'd0,  10'd3},
        '{2'd0, 2'd3, 2'd0, 2'd1, 2'd3, 1'b0, 10'd5,  10'd0},
        '{2'd1, 2'd0, 2'd3, 2'd3, 2'd3, 1'b1, 10'd0,  10'd0},
        '{2'd1, 2'd1, 2'd3, 2'd3, 2'd3, 1'b0, 10'd4,  10'd4},
        '{2'd2, 2'd0, 2'd2, 2'd0, 2'd0, 1'b1, 10'd0,  10'd2},
        '{2'd2, 2'd0, 2'd2, 2'd0, 2'd0, 1'b0, 10'd1,  10'd2},
        '{2'd2, 2'd1, 2'd0, 2'd3, 2'd0, 1'b1, 10'd6,  10'd6},
        '{2'd2, 2'd2, 2'd0, 2'd0, 2'd1, 1'b0, 10'd2,  10'd2},
        '{2'd3, 2'd2, 2'd0, 2'd0, 2'd2, 1'b1, 10'd9,  10'd2},
        '{2'd1, 2'd2, 2'd0, 2'd0, 2'd0, 1'b1, 10'd1,  10'd1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_cycle(input logic [1:0] md, input logic [1:0] rg,
                             input logic [1:0] fd, input logic [1:0] fe,
                             input logic [1:0] fc, input logic rd,
                             input int rel, input int exp_tw,
                             input string tag, input bit poke);
        int tw = 0;
        int len = 0;
        int dn = 0;
        int bad_strobe = 0;
        int bad_step = 0;
        int first_st = 0;
        logic [2:0] prev;
        @(negedge clk);
        mode = md; region = rg; wc_def = fd; wc_ext = fe; wc_cp = fc;
        rd_sel = rd; wait_n = (rel == 0);
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        prev = 3'(ST_IDLE);
        for (int j = 0; j < 2000; j++) begin
            logic act_strobe;
            if (j == 0) begin
                first_st = int'(bus_state);
                // R11: scramble configuration after the start edge
                mode = ~md; region = ~rg; wc_def = ~fd; wc_ext = ~fe;
                wc_cp = ~fc; rd_sel = ~rd;
            end
            if (poke && j == 2) start = 1'b1;
            if (poke && j == 3) start = 1'b0;
            len++;
            if (bus_state == 3'(ST_TW)) tw++;
            if (done) dn++;
            act_strobe = (bus_state == 3'(ST_T2) || bus_state == 3'(ST_TW) ||
                          bus_state == 3'(ST_T3));
            if (rd_stb != (rd && act_strobe) || wr_stb != (!rd && act_strobe))
                bad_strobe++;
            if (done != (bus_state == 3'(ST_T3))) bad_strobe++;
            unique case (prev)
                3'(ST_IDLE): if (bus_state != 3'(ST_T1)) bad_step++;
                3'(ST_T1):   if (bus_state != 3'(ST_T2)) bad_step++;
                3'(ST_T2), 3'(ST_TW):
                    if (bus_state != 3'(ST_TW) && bus_state != 3'(ST_T3)) bad_step++;
                default: bad_step++;
            endcase
            prev = bus_state;
            if (rel > 0 && j == rel) wait_n = 1'b1;
            if (bus_state == 3'(ST_T3) || bad_step != 0) break;
            @(negedge clk);
        end
        check(first_st == int'(ST_T1), {tag, " R1 first state"}, first_st, int'(ST_T1));
        check(tw == exp_tw, {tag, " wait count"}, tw, exp_tw);
        check(len == exp_tw + 3, {tag, " R1 cycle length"}, len, exp_tw + 3);
        check(bad_step == 0, {tag, " R1 state order"}, bad_step, 0);
        check(bad_strobe == 0, {tag, " R9 R10 strobes"}, bad_strobe, 0);
        check(dn == 1, {tag, " R10 done count"}, dn, 1);
        wait_n = 1'b1;
        @(negedge clk);
        check(bus_state == 3'(ST_IDLE), {tag, " R1 R2 back to idle"},
              int'(bus_state), int'(ST_IDLE));
        repeat (2) @(negedge clk);
        check(bus_state == 3'(ST_IDLE), {tag, " R2 stays idle"},
              int'(bus_state), int'(ST_IDLE));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        string tag;
        // R12: reset state, also with start raised during reset
        start = 1'b1;
        repeat (3) @(negedge clk);
        check(bus_state == 3'(ST_IDLE) && !rd_stb && !wr_stb && !done,
              "R12 in reset", int'(bus_state), int'(ST_IDLE));
        start = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(bus_state == 3'(ST_IDLE) && !rd_stb && !wr_stb && !done,
              "R12 after reset", int'(bus_state), int'(ST_IDLE));

        foreach (VECS[i]) begin
            if (VECS[i].md == 2'd1)      tag = "R5 R7";
            else if (VECS[i].md == 2'd2) tag = "R6 R7";
            else                         tag = "R3 R4";
            run_cycle(VECS[i].md, VECS[i].rg, VECS[i].fd, VECS[i].fe, VECS[i].fc,
                      VECS[i].rd, int'(VECS[i].rel), int'(VECS[i].exp_tw),
                      tag, 1'b0);
        end

        // R2: start pulse during a running cycle
        run_cycle(2'd0, 2'd2, 2'd0, 2'd0, 2'd3, 1'b0, 0, 3, "R2", 1'b1);
        // R11: config scrambled mid-cycle in a combined-mode read
        run_cycle(2'd2, 2'd1, 2'd3, 2'd1, 2'd2, 1'b1, 0, 1, "R11", 1'b0);
        // R8: WAIT held low for a long time
        run_cycle(2'd2, 2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 300, 300, "R8 combined", 1'b0);
        run_cycle(2'd1, 2'd3, 2'd3, 2'd3, 2'd3, 1'b1, 150, 150, "R8 pin only", 1'b0);
        // R3: programmed mode ignores a long low WAIT
        run_cycle(2'd0, 2'd0, 2'd3, 2'd0, 2'd0, 1'b0, 200, 3, "R3 long wait", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule